// File: doc/BRIEF.md
# Split-Word 64-bit Machine Timer

This block is a timer peripheral that sits on a 32-bit register bus. It keeps a free-running time counter and a compare value, each twice the bus width. Software sees each one as a pair of bus words. The counter advances by one on every cycle in which the tick-enable input is high. The timer interrupt is a level output. It is high for as long as the counter is at or above the compare value.

The two halves of a wide register are not latched as a pair. A write to one compare word changes the comparison on the next cycle, so the order of the writes matters. A carry can also ripple into the upper counter half between two reads. A build-time option, `SNAPSHOT`, addresses the read case. When it is set, reading the low time word also records the upper counter half, and a later read of the high time word returns that recorded value. When it is clear, the high word is always read live. The interrupt is never cleared by the hardware: software drops it by raising the compare value above the time.

Top module: `split_word_timer`

## Requirements
- R1: After reset, time is zero, compare is all ones, `timer_irq` is low, `bus_rdata` is zero, and the snapshot copy is zero.
- R2: The time counter increments by one on each clock edge where `tick_en` is high and no time word is written. It holds when `tick_en` is low. It wraps from all ones to zero.
- R3: `timer_irq` is high exactly when time is greater than or equal to compare, both taken as unsigned values. Equality counts as reached.
- R4: Each compare word write replaces only its own half on the following edge. The comparison uses the partly updated value at once, so an intermediate value can raise the interrupt.
- R5: Once raised, `timer_irq` stays high through idle cycles and counting. It falls only after compare is rewritten above time, or after the counter wraps.
- R6: A write to a time word replaces only that half. The write takes precedence over `tick_en` on that edge, and counting resumes from the written value on the next edge.
- R7: Byte offset 0 holds time bits [W-1:0], offset 4 holds time bits [2W-1:W], offset 8 holds compare bits [W-1:0], and offset 12 holds compare bits [2W-1:W], where W is the bus width. Read data for a read access (`bus_valid`=1, `bus_write`=0) appears on `bus_rdata` after the next clock edge and holds until the next read.
- R8: A read of any other offset returns zero. A write to any other offset changes neither time nor compare.
- R9: With `SNAPSHOT`=0, a read of offset 4 returns the live upper counter half.
- R10: With `SNAPSHOT`=1, a read of offset 0 records the upper counter half present at that edge. Reads of offset 4 return that record, not the live value, and a read of offset 4 does not refresh it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Time-base enable, one count per high cycle |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| timer_irq | output | 1 | Level interrupt, time >= compare |

## Verification
The bench builds two copies with an 8-bit bus: one with `SNAPSHOT`=1 and one with `SNAPSHOT`=0, driven side by side. The 8-bit bus shrinks the counter to 16 bits. That makes it possible to sweep every counter value against one compare value, which covers the equality edge and the wrap back to zero. It also makes carries from low to high half easy to provoke, so torn reads, transient compare values and the difference between the live and snapshot high-word reads can all be set up with a few writes.

// File: rtl/swt_pkg.sv
package swt_pkg;

  // Byte offsets of the four words; software depends on this layout.
  localparam int OFS_TIME_LO = 0;
  localparam int OFS_TIME_HI = 4;
  localparam int OFS_CMP_LO  = 8;
  localparam int OFS_CMP_HI  = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TIME_LO,
    SEL_TIME_HI,
    SEL_CMP_LO,
    SEL_CMP_HI
  } reg_sel_e;

endpackage

// File: rtl/swt_regdec.sv
module swt_regdec #(
  parameter int ADDR_W = 4
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output swt_pkg::reg_sel_e sel,
  output logic              rd_en,
  output logic              wr_time_lo,
  output logic              wr_time_hi,
  output logic              wr_cmp_lo,
  output logic              wr_cmp_hi
);
  import swt_pkg::*;

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFS_TIME_LO))      sel = SEL_TIME_LO;
    else if (bus_addr == ADDR_W'(OFS_TIME_HI)) sel = SEL_TIME_HI;
    else if (bus_addr == ADDR_W'(OFS_CMP_LO))  sel = SEL_CMP_LO;
    else if (bus_addr == ADDR_W'(OFS_CMP_HI))  sel = SEL_CMP_HI;
  end

  always_comb begin
    rd_en      = bus_valid && !bus_write;
    wr_time_lo = bus_valid && bus_write && (sel == SEL_TIME_LO);
    wr_time_hi = bus_valid && bus_write && (sel == SEL_TIME_HI);
    wr_cmp_lo  = bus_valid && bus_write && (sel == SEL_CMP_LO);
    wr_cmp_hi  = bus_valid && bus_write && (sel == SEL_CMP_HI);
  end

endmodule

// File: rtl/swt_counter.sv
module swt_counter #(
  parameter  int DATA_W = 32,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [TIME_W-1:0] cnt_q
);

  logic [TIME_W-1:0] cnt_d;
  logic              cnt_en;

  // A word write wins over the tick on the same edge.
  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo)        cnt_d[DATA_W-1:0]      = wdata;
    else if (wr_hi)   cnt_d[TIME_W-1:DATA_W] = wdata;
    else if (tick_en) cnt_d                  = cnt_q + TIME_W'(1);
  end

  assign cnt_en = wr_lo || wr_hi || tick_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/swt_compare.sv
module swt_compare #(
  parameter  int DATA_W = 32,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TIME_W-1:0] cnt,
  output logic [TIME_W-1:0] cmp_q,
  output logic              irq
);

  logic [TIME_W-1:0] cmp_d;
  logic              cmp_en;

  // Halves update independently; no staging of a pair.
  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo) cmp_d[DATA_W-1:0]      = wdata;
    if (wr_hi) cmp_d[TIME_W-1:DATA_W] = wdata;
  end

  assign cmp_en = wr_lo || wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_en) cmp_q <= cmp_d;
  end

  assign irq = (cnt >= cmp_q);

endmodule

// File: rtl/swt_readmux.sv
module swt_readmux #(
  parameter  int DATA_W   = 32,
  parameter  bit SNAPSHOT = 1'b0,
  localparam int TIME_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  swt_pkg::reg_sel_e sel,
  input  logic [TIME_W-1:0] cnt,
  input  logic [TIME_W-1:0] cmp,
  output logic [DATA_W-1:0] rdata_q
);
  import swt_pkg::*;

  logic [DATA_W-1:0] time_hi_view;
  logic [DATA_W-1:0] rdata_d;

  generate
    if (SNAPSHOT) begin : g_snap
      logic [DATA_W-1:0] snap_q;
      logic              snap_en;

      // Only the upper half is kept: the lower half is returned by the same read.
      assign snap_en = rd_en && (sel == SEL_TIME_LO);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_q <= '0;
        else if (snap_en) snap_q <= cnt[TIME_W-1:DATA_W];
      end

      assign time_hi_view = snap_q;
    end else begin : g_live
      assign time_hi_view = cnt[TIME_W-1:DATA_W];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_TIME_LO: rdata_d = cnt[DATA_W-1:0];
      SEL_TIME_HI: rdata_d = time_hi_view;
      SEL_CMP_LO:  rdata_d = cmp[DATA_W-1:0];
      SEL_CMP_HI:  rdata_d = cmp[TIME_W-1:DATA_W];
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

endmodule

// File: rtl/split_word_timer.sv
module split_word_timer #(
  parameter  int DATA_W   = 32,
  parameter  int ADDR_W   = 4,
  parameter  bit SNAPSHOT = 1'b0,
  localparam int TIME_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              timer_irq
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  swt_pkg::reg_sel_e sel;
  logic              rd_en;
  logic              wr_time_lo;
  logic              wr_time_hi;
  logic              wr_cmp_lo;
  logic              wr_cmp_hi;
  logic [TIME_W-1:0] cnt;
  logic [TIME_W-1:0] cmp;

  swt_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .sel        (sel),
    .rd_en      (rd_en),
    .wr_time_lo (wr_time_lo),
    .wr_time_hi (wr_time_hi),
    .wr_cmp_lo  (wr_cmp_lo),
    .wr_cmp_hi  (wr_cmp_hi)
  );

  swt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick_en (tick_en),
    .wr_lo   (wr_time_lo),
    .wr_hi   (wr_time_hi),
    .wdata   (bus_wdata),
    .cnt_q   (cnt)
  );

  swt_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_lo (wr_cmp_lo),
    .wr_hi (wr_cmp_hi),
    .wdata (bus_wdata),
    .cnt   (cnt),
    .cmp_q (cmp),
    .irq   (timer_irq)
  );

  swt_readmux #(.DATA_W(DATA_W), .SNAPSHOT(SNAPSHOT)) u_rd (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .rd_en   (rd_en),
    .sel     (sel),
    .cnt     (cnt),
    .cmp     (cmp),
    .rdata_q (bus_rdata)
  );

endmodule

// File: rtl/swt_chk.sv
module swt_chk #(
  parameter  int DATA_W = 32,
  parameter  int ADDR_W = 4,
  localparam int TIME_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              timer_irq,
  input logic [TIME_W-1:0] cnt,
  input logic [TIME_W-1:0] cmp
);
  import swt_pkg::*;

  logic any_wr;
  logic mapped;

  assign any_wr = bus_valid && bus_write;
  assign mapped = (bus_addr == ADDR_W'(OFS_TIME_LO)) || (bus_addr == ADDR_W'(OFS_TIME_HI)) ||
                  (bus_addr == ADDR_W'(OFS_CMP_LO))  || (bus_addr == ADDR_W'(OFS_CMP_HI));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !any_wr) |=> (cnt == $past(cnt) + TIME_W'(1)));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !any_wr) |=> $stable(cnt));

  // R6
  time_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && bus_addr == ADDR_W'(OFS_TIME_LO)) |=>
      (cnt[DATA_W-1:0] == $past(bus_wdata)) &&
      (cnt[TIME_W-1:DATA_W] == $past(cnt[TIME_W-1:DATA_W])));

  // R4
  cmp_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && bus_addr == ADDR_W'(OFS_CMP_LO)) |=>
      (cmp[DATA_W-1:0] == $past(bus_wdata)) &&
      (cmp[TIME_W-1:DATA_W] == $past(cmp[TIME_W-1:DATA_W])));

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_irq && !any_wr && !(tick_en && (&cnt))) |=> timer_irq);

  // R7
  time_lo_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(OFS_TIME_LO)) |=>
      (bus_rdata == $past(cnt[DATA_W-1:0])));

  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !mapped) |=> (bus_rdata == '0));

endmodule

bind split_word_timer swt_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .tick_en   (tick_en),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .timer_irq (timer_irq),
  .cnt       (cnt),
  .cmp       (cmp)
);

// File: tb/split_word_timer_tb_top.sv
module split_word_timer_tb_top;

  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk;
  logic          rst_n;
  logic          tick_en;
  logic          bus_valid;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] rdata_s;
  logic [DW-1:0] rdata_l;
  logic          irq_s;
  logic          irq_l;

  int  checks;
  int  errors;
  bit  done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  split_word_timer #(.DATA_W(DW), .ADDR_W(AW), .SNAPSHOT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_s), .timer_irq(irq_s));

  split_word_timer #(.DATA_W(DW), .ADDR_W(AW), .SNAPSHOT(1'b0)) dut_live_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_l), .timer_irq(irq_l));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] rs, output logic [DW-1:0] rl);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    rs = rdata_s;
    rl = rdata_l;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rs, rl;
    logic [15:0]   cval;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'd0, irq_s}, 32'd0);
    chk("R1 rdata in reset", {24'd0, rdata_s}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(4'd0, rs, rl);
    chk("R1 time lo", {24'd0, rs}, 32'd0);
    bus_rd(4'd4, rs, rl);
    chk("R1 R10 snapshot hi after reset", {24'd0, rs}, 32'd0);
    chk("R1 time hi live", {24'd0, rl}, 32'd0);
    bus_rd(4'd8, rs, rl);
    chk("R1 R7 cmp lo", {24'd0, rs}, 32'hFF);
    bus_rd(4'd12, rs, rl);
    chk("R1 R7 cmp hi", {24'd0, rl}, 32'hFF);
    chk("R1 irq after reset", {30'd0, irq_s, irq_l}, 32'd0);

    // R2: hold, count, gated count, wrap
    bus_wr(4'd0, 8'h10);
    repeat (5) @(negedge clk);
    bus_rd(4'd0, rs, rl);
    chk("R2 hold with tick low", {24'd0, rs}, 32'h10);
    ticks(7);
    bus_rd(4'd0, rs, rl);
    chk("R2 seven ticks", {24'd0, rs}, 32'h17);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      tick_en = (i % 2 == 0);
    end
    @(negedge clk);
    tick_en = 1'b0;
    bus_rd(4'd0, rs, rl);
    chk("R2 alternating ticks", {24'd0, rs}, 32'h1C);
    bus_wr(4'd0, 8'hFB);
    bus_wr(4'd4, 8'hFF);
    ticks(10);
    bus_rd(4'd0, rs, rl);
    chk("R2 wrap lo", {24'd0, rs}, 32'h05);
    bus_rd(4'd4, rs, rl);
    chk("R2 wrap hi snapshot", {24'd0, rs}, 32'h00);
    chk("R2 wrap hi live", {24'd0, rl}, 32'h00);

    // R6: time write beats tick, counting resumes after
    bus_wr(4'd0, 8'h30);
    bus_wr(4'd4, 8'h00);
    @(negedge clk);
    tick_en = 1'b1; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'd0; bus_wdata = 8'h40;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tick_en = 1'b0;
    bus_rd(4'd0, rs, rl);
    chk("R6 write wins over tick", {24'd0, rs}, 32'h40);
    @(negedge clk);
    tick_en = 1'b1; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'd4; bus_wdata = 8'h22;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    @(negedge clk);
    tick_en = 1'b0;
    bus_rd(4'd0, rs, rl);
    chk("R6 resume lo", {24'd0, rs}, 32'h41);
    bus_rd(4'd4, rs, rl);
    chk("R6 hi half written", {24'd0, rl}, 32'h22);

    // R3 / R4: word-wise compare writes, transient value, equality
    bus_wr(4'd0, 8'h20);
    bus_wr(4'd4, 8'h01);
    bus_wr(4'd8, 8'h00);
    chk("R3 cmp FF00 above time", {31'd0, irq_s}, 32'd0);
    bus_wr(4'd12, 8'h00);
    chk("R3 cmp 0000 below time", {31'd0, irq_s}, 32'd1);
    bus_wr(4'd12, 8'h01);
    chk("R3 cmp 0100", {31'd0, irq_l}, 32'd1);
    bus_wr(4'd8, 8'h50);
    chk("R3 cmp 0150", {31'd0, irq_s}, 32'd0);
    bus_wr(4'd8, 8'h05);
    chk("R4 transient cmp 0105 fires", {31'd0, irq_s}, 32'd1);
    bus_wr(4'd12, 8'h02);
    chk("R4 final cmp 0205 clears", {31'd0, irq_s}, 32'd0);
    bus_rd(4'd8, rs, rl);
    chk("R7 cmp lo readback", {24'd0, rs}, 32'h05);
    bus_rd(4'd12, rs, rl);
    chk("R7 cmp hi readback", {24'd0, rs}, 32'h02);
    bus_wr(4'd8, 8'h20);
    bus_wr(4'd12, 8'h01);
    chk("R3 equality fires", {30'd0, irq_s, irq_l}, 32'd3);
    bus_wr(4'd8, 8'h21);
    chk("R3 one above time", {30'd0, irq_s, irq_l}, 32'd0);

    // R5: sticky until compare is raised
    bus_wr(4'd8, 8'h00);
    chk("R5 raised", {31'd0, irq_s}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R5 held idle", {31'd0, irq_s}, 32'd1);
    ticks(20);
    chk("R5 held counting", {31'd0, irq_s}, 32'd1);
    bus_wr(4'd12, 8'hFF);
    chk("R5 cleared by raising compare", {31'd0, irq_s}, 32'd0);

    // R8: unmapped offsets
    bus_wr(4'd2, 8'hAA);
    bus_wr(4'd15, 8'h55);
    bus_wr(4'd5, 8'h00);
    bus_rd(4'd0, rs, rl);
    chk("R8 time lo untouched", {24'd0, rs}, 32'h34);
    bus_rd(4'd4, rs, rl);
    chk("R8 time hi untouched", {24'd0, rl}, 32'h01);
    bus_rd(4'd8, rs, rl);
    chk("R8 cmp lo untouched", {24'd0, rs}, 32'h00);
    bus_rd(4'd12, rs, rl);
    chk("R8 cmp hi untouched", {24'd0, rs}, 32'hFF);
    bus_rd(4'd2, rs, rl);
    chk("R8 read offset 2", {24'd0, rs}, 32'd0);
    bus_rd(4'd13, rs, rl);
    chk("R8 read offset 13", {24'd0, rl}, 32'd0);

    // R9 / R10: carry between the low and high reads
    bus_wr(4'd0, 8'hFF);
    bus_wr(4'd4, 8'h12);
    @(negedge clk);
    tick_en = 1'b1; bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 4'd0;
    @(negedge clk);
    chk("R7 lo before carry", {24'd0, rdata_s}, 32'hFF);
    tick_en = 1'b0; bus_addr = 4'd4;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R10 snapshot hi matches lo", {24'd0, rdata_s}, 32'h12);
    chk("R9 live hi shows carry", {24'd0, rdata_l}, 32'h13);
    bus_rd(4'd4, rs, rl);
    chk("R10 hi read does not refresh", {24'd0, rs}, 32'h12);
    chk("R9 live hi again", {24'd0, rl}, 32'h13);

    // R3 / R2: full sweep of the 16-bit counter against one compare value
    cval = 16'h9A3C;
    bus_wr(4'd8, cval[7:0]);
    bus_wr(4'd12, cval[15:8]);
    bus_wr(4'd0, 8'h00);
    bus_wr(4'd4, 8'h00);
    @(negedge clk);
    tick_en = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      chk("R3 sweep", {30'd0, irq_s, irq_l}, (i >= int'(cval)) ? 32'd3 : 32'd0);
      @(negedge clk);
    end
    tick_en = 1'b0;
    chk("R2 R5 wrap drops irq", {30'd0, irq_s, irq_l}, 32'd0);
    bus_rd(4'd0, rs, rl);
    chk("R2 wrapped to zero", {24'd0, rs}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule